// File: doc/BRIEF.md
# Sector-Range Flash Erase Sequencer

This block erases a contiguous run of sectors in a bank of byte-wide parallel flash devices that share one address bus and sit side by side on a wide data bus, one byte lane per device. A request gives a start address, a byte count, a per-device enable mask and a device family selector. The block first checks that both the start and the count are whole multiples of the family's sector size. If they are not, it refuses the request without touching the bus. If they are, it drives the unlock and erase command writes, then the status polling reads, over a simple request/acknowledge bus-cycle port.

Two device families are handled. Family A (small 4 KiB sectors) needs a complete command sequence and a completion wait for every sector. Family B (64 KiB sectors) accepts a whole batch of sector addresses after a single command setup and is then polled once. Its lowest sector is split into smaller boot pieces, so a range that begins at address 0 has that first sector replaced by the four boot piece addresses. When the operation ends, the block gives a one-cycle done pulse together with a success flag.

Top module: `sector_erase`

## Requirements
- R1: After reset, and at any time the block is idle, busy and done are low and no bus request is raised.
- R2: A request whose start address or length is not a multiple of the sector size ends with a done pulse and ok low, and raises no bus request. The sector size is 4 KiB when devType is 0 (family A) and 64 KiB when devType is 1 (family B).
- R3: An aligned request with length 0 ends with a done pulse and ok high, and raises no bus request.
- R4: An unlock pair is two writes. The first puts 0xAA in every enabled lane at address U. The second puts 0x55 in every enabled lane at address ~U. U is 0x555555 for family A and 0xAAAAAA for family B. chipSel bit i enables lane i, which is busWdata bits 8i+7..8i. Disabled lanes carry 0x00.
- R5: The erase setup is an unlock pair, then a write of 0x80 in all lanes at U, then a second unlock pair. Every sector address write carries 0x30 in all lanes.
- R6: For family A, each sector in ascending address order gets the full setup, its own sector write and its own completion wait before the next sector begins.
- R7: For family B, the setup is issued once. All sector addresses follow in ascending order, and a single completion wait comes after the last one.
- R8: For family B with start address 0, the first 64 KiB sector is written as four sector writes at 0x0000, 0x4000, 0x6000 and 0x8000.
- R9: A completion wait reads address 0 repeatedly and ends at the first read that returns the same value as the read just before it.
- R10: done is a single-cycle pulse raised only after the last completion wait, with busy already low. ok is valid while done is high.
- R11: A start request raised while busy is ignored. It produces no extra bus cycles and no extra done pulse.
- R12: Once a bus request is raised, it stays raised with unchanged address, write data and direction until the cycle in which busAck is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start an erase; sampled only while idle |
| devType | input | 1 | Device family: 0 = A (4 KiB sectors), 1 = B (64 KiB sectors) |
| startAddr | input | ADDR_W | First byte address of the range |
| eraseLen | input | ADDR_W+1 | Length of the range in bytes |
| chipSel | input | LANES | Per-device enable, bit i for lane i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| ok | output | 1 | Success flag, valid with done |
| busReq | output | 1 | Bus cycle request |
| busWrite | output | 1 | 1 = write cycle, 0 = read cycle |
| busAddr | output | ADDR_W | Bus cycle address |
| busWdata | output | 8*LANES | Write data, one byte per lane |
| busAck | input | 1 | Bus cycle completes in a cycle with busReq and busAck high |
| busRdata | input | 8*LANES | Read data, valid with busAck on a read |

## Verification
The bench uses the default build: four lanes, a 24-bit address, and 2^12 and 2^16 byte sectors. With these values the boot split at address 0, two-sector ranges for both families, and offsets that are aligned for family A but not for family B can all be reached with runs of only a few dozen bus cycles. Its bus model makes each erase look busy for three toggling status reads, so every completion wait has to reject several changing pairs before it sees a matching one.

// File: rtl/sector_erase_pkg.sv
package sector_erase_pkg;

  typedef enum logic [2:0] {
    OP_UNLOCK_A  = 3'd0,
    OP_UNLOCK_B  = 3'd1,
    OP_SETUP_CMD = 3'd2,
    OP_SECTOR    = 3'd3,
    OP_BOOT      = 3'd4,
    OP_POLL      = 3'd5
  } busOpE;

  typedef struct packed {
    logic  load;
    logic  advance;
    logic  bootInc;
    logic  capture;
    busOpE op;
  } eraseStrobeT;

  localparam int BOOT_PIECES = 4;

endpackage

// File: rtl/sector_erase_dpath.sv
module sector_erase_dpath
  import sector_erase_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LANES       = 4,
  parameter int SECT_A_LOG2 = 12,
  parameter int SECT_B_LOG2 = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  eraseStrobeT          strobe,
  input  logic                 reqType,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [ADDR_W:0]      reqLen,
  input  logic [LANES-1:0]     reqMask,
  input  logic [8*LANES-1:0]   busRdata,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [8*LANES-1:0]   busWdata,
  output logic                 busWrite,
  output logic                 typeB,
  output logic                 aligned,
  output logic                 lenZero,
  output logic                 lastSector,
  output logic                 atZero,
  output logic                 bootLast,
  output logic                 pollMatch
);

  localparam int LEN_W  = ADDR_W + 1;
  localparam int DATA_W = 8 * LANES;
  localparam logic [LEN_W-1:0] SIZE_A = LEN_W'(1) << SECT_A_LOG2;
  localparam logic [LEN_W-1:0] SIZE_B = LEN_W'(1) << SECT_B_LOG2;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [LANES-1:0]  laneSel;
  logic [DATA_W-1:0] lastRead;
  logic [1:0]        bootIdx;

  logic [LEN_W-1:0]  sectSize;
  logic [LEN_W-1:0]  sectMask;
  logic [DATA_W-1:0] laneMask;
  logic [ADDR_W-1:0] patEven;
  logic [ADDR_W-1:0] unlockAddr;
  logic [ADDR_W-1:0] bootAddr;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign laneMask[8*gi +: 8] = {8{laneSel[gi]}};
    end
    for (gi = 0; gi < ADDR_W; gi++) begin : g_pat
      assign patEven[gi] = ((gi % 2) == 0);
    end
  endgenerate

  assign sectSize   = typeB ? SIZE_B : SIZE_A;
  assign sectMask   = sectSize - LEN_W'(1);
  assign unlockAddr = typeB ? ~patEven : patEven;

  assign aligned    = (({1'b0, curAddr} & sectMask) == '0) && ((remLen & sectMask) == '0);
  assign lenZero    = (remLen == '0);
  assign lastSector = (remLen == sectSize);
  assign atZero     = (curAddr == '0);
  assign bootLast   = (bootIdx == 2'(BOOT_PIECES - 1));
  assign pollMatch  = (busRdata == lastRead);

  always_comb begin
    case (bootIdx)
      2'd0:    bootAddr = '0;
      2'd1:    bootAddr = ADDR_W'(32'h4000);
      2'd2:    bootAddr = ADDR_W'(32'h6000);
      default: bootAddr = ADDR_W'(32'h8000);
    endcase
  end

  always_comb begin
    busWrite = 1'b1;
    case (strobe.op)
      OP_UNLOCK_A: begin
        busAddr  = unlockAddr;
        busWdata = {LANES{8'hAA}} & laneMask;
      end
      OP_UNLOCK_B: begin
        busAddr  = ~unlockAddr;
        busWdata = {LANES{8'h55}} & laneMask;
      end
      OP_SETUP_CMD: begin
        busAddr  = unlockAddr;
        busWdata = {LANES{8'h80}};
      end
      OP_SECTOR: begin
        busAddr  = curAddr;
        busWdata = {LANES{8'h30}};
      end
      OP_BOOT: begin
        busAddr  = bootAddr;
        busWdata = {LANES{8'h30}};
      end
      default: begin
        busAddr  = '0;
        busWdata = '0;
        busWrite = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      remLen   <= '0;
      laneSel  <= '0;
      typeB    <= 1'b0;
      lastRead <= '0;
      bootIdx  <= '0;
    end else begin
      if (strobe.load) begin
        curAddr <= reqAddr;
        remLen  <= reqLen;
        laneSel <= reqMask;
        typeB   <= reqType;
        bootIdx <= '0;
      end else begin
        if (strobe.advance) begin
          curAddr <= curAddr + sectSize[ADDR_W-1:0];
          remLen  <= remLen - sectSize;
        end
        if (strobe.bootInc) begin
          bootIdx <= bootIdx + 2'd1;
        end
      end
      if (strobe.capture) begin
        lastRead <= busRdata;
      end
    end
  end

endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
  import sector_erase_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        busAck,
  input  logic        typeB,
  input  logic        aligned,
  input  logic        lenZero,
  input  logic        lastSector,
  input  logic        atZero,
  input  logic        bootLast,
  input  logic        pollMatch,
  output eraseStrobeT strobe,
  output logic        busReq,
  output logic        busy,
  output logic        done,
  output logic        ok
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_SETUP, ST_BOOT, ST_SECTOR, ST_POLL1, ST_POLL2
  } ctrlStateE;

  ctrlStateE  state;
  logic [2:0] setupStep;
  logic       fire;

  assign busReq = (state == ST_SETUP) || (state == ST_BOOT) || (state == ST_SECTOR) ||
                  (state == ST_POLL1) || (state == ST_POLL2);
  assign fire   = busReq && busAck;
  assign busy   = (state != ST_IDLE);

  always_comb begin
    strobe.load    = (state == ST_IDLE) && startReq;
    strobe.advance = fire && ((state == ST_SECTOR) || ((state == ST_BOOT) && bootLast));
    strobe.bootInc = fire && (state == ST_BOOT);
    strobe.capture = fire && ((state == ST_POLL1) || ((state == ST_POLL2) && !pollMatch));
    case (state)
      ST_SETUP: begin
        case (setupStep)
          3'd0, 3'd3: strobe.op = OP_UNLOCK_A;
          3'd1, 3'd4: strobe.op = OP_UNLOCK_B;
          default:    strobe.op = OP_SETUP_CMD;
        endcase
      end
      ST_BOOT:   strobe.op = OP_BOOT;
      ST_SECTOR: strobe.op = OP_SECTOR;
      default:   strobe.op = OP_POLL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      setupStep <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!aligned) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            ok    <= 1'b0;
          end else if (lenZero) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            ok    <= 1'b1;
          end else begin
            state     <= ST_SETUP;
            setupStep <= '0;
          end
        end
        ST_SETUP: begin
          if (fire) begin
            if (setupStep == 3'd4) begin
              setupStep <= '0;
              state     <= (typeB && atZero) ? ST_BOOT : ST_SECTOR;
            end else begin
              setupStep <= setupStep + 3'd1;
            end
          end
        end
        ST_BOOT: begin
          if (fire && bootLast) state <= lastSector ? ST_POLL1 : ST_SECTOR;
        end
        ST_SECTOR: begin
          if (fire && (!typeB || lastSector)) state <= ST_POLL1;
        end
        ST_POLL1: begin
          if (fire) state <= ST_POLL2;
        end
        ST_POLL2: begin
          if (fire && pollMatch) begin
            if (typeB || lenZero) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              ok    <= 1'b1;
            end else begin
              state     <= ST_SETUP;
              setupStep <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sector_erase.sv
module sector_erase
  import sector_erase_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LANES       = 4,
  parameter int SECT_A_LOG2 = 12,
  parameter int SECT_B_LOG2 = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 devType,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [ADDR_W:0]      eraseLen,
  input  logic [LANES-1:0]     chipSel,
  output logic                 busy,
  output logic                 done,
  output logic                 ok,
  output logic                 busReq,
  output logic                 busWrite,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [8*LANES-1:0]   busWdata,
  input  logic                 busAck,
  input  logic [8*LANES-1:0]   busRdata
);

  eraseStrobeT strobe;
  logic typeB, aligned, lenZero, lastSector, atZero, bootLast, pollMatch;

  sector_erase_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .busAck     (busAck),
    .typeB      (typeB),
    .aligned    (aligned),
    .lenZero    (lenZero),
    .lastSector (lastSector),
    .atZero     (atZero),
    .bootLast   (bootLast),
    .pollMatch  (pollMatch),
    .strobe     (strobe),
    .busReq     (busReq),
    .busy       (busy),
    .done       (done),
    .ok         (ok)
  );

  sector_erase_dpath #(
    .ADDR_W      (ADDR_W),
    .LANES       (LANES),
    .SECT_A_LOG2 (SECT_A_LOG2),
    .SECT_B_LOG2 (SECT_B_LOG2)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqType    (devType),
    .reqAddr    (startAddr),
    .reqLen     (eraseLen),
    .reqMask    (chipSel),
    .busRdata   (busRdata),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busWrite   (busWrite),
    .typeB      (typeB),
    .aligned    (aligned),
    .lenZero    (lenZero),
    .lastSector (lastSector),
    .atZero     (atZero),
    .bootLast   (bootLast),
    .pollMatch  (pollMatch)
  );

endmodule

// File: rtl/sector_erase_checker.sv
module sector_erase_checker #(
  parameter int ADDR_W      = 24,
  parameter int LANES       = 4,
  parameter int SECT_A_LOG2 = 12,
  parameter int SECT_B_LOG2 = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               startReq,
  input logic               devType,
  input logic [ADDR_W-1:0]  startAddr,
  input logic [ADDR_W:0]    eraseLen,
  input logic               busy,
  input logic               done,
  input logic               ok,
  input logic               busReq,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [8*LANES-1:0] busWdata,
  input logic               busAck
);

  localparam int LEN_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0] MASK_A = (LEN_W'(1) << SECT_A_LOG2) - LEN_W'(1);
  localparam logic [LEN_W-1:0] MASK_B = (LEN_W'(1) << SECT_B_LOG2) - LEN_W'(1);

  logic [LEN_W-1:0] reqMask;
  logic             reqMisaligned;

  assign reqMask       = devType ? MASK_B : MASK_A;
  assign reqMisaligned = (({1'b0, startAddr} & reqMask) != '0) || ((eraseLen & reqMask) != '0);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq);

  assert_misaligned_refused_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && reqMisaligned) |=> !busReq ##1 (done && !ok));

  assert_poll_at_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite) |-> (busAddr == '0));

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWdata) && $stable(busWrite)));

endmodule

bind sector_erase sector_erase_checker #(
  .ADDR_W      (ADDR_W),
  .LANES       (LANES),
  .SECT_A_LOG2 (SECT_A_LOG2),
  .SECT_B_LOG2 (SECT_B_LOG2)
) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .devType   (devType),
  .startAddr (startAddr),
  .eraseLen  (eraseLen),
  .busy      (busy),
  .done      (done),
  .ok        (ok),
  .busReq    (busReq),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busAck    (busAck)
);

// File: tb/test_sector_erase.sv
`timescale 1ns/1ps
module test_sector_erase;

  localparam int ADDR_W = 24;
  localparam int LANES  = 4;
  localparam int LEN_W  = ADDR_W + 1;
  localparam int DEPTH  = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic devType = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [LEN_W-1:0]  eraseLen = '0;
  logic [LANES-1:0]  chipSel = '0;
  logic busy, done, ok, busReq, busWrite;
  logic [ADDR_W-1:0] busAddr;
  logic [31:0] busWdata;
  logic busAck;
  logic [31:0] busRdata;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sector_erase i_sector_erase (
    .clk(clk), .rstN(rstN), .startReq(startReq), .devType(devType),
    .startAddr(startAddr), .eraseLen(eraseLen), .chipSel(chipSel),
    .busy(busy), .done(done), .ok(ok), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata)
  );

  // Bus model: ack one cycle after request, status toggles for three reads after each 0x30 write
  logic        logW [DEPTH];
  logic [23:0] logA [DEPTH];
  logic [31:0] logD [DEPTH];
  int          logN = 0;
  int          busyRemain = 0;
  logic        togBit = 1'b0;
  int          doneCount = 0;

  assign busRdata = (busyRemain > 0) ? (togBit ? 32'h40404040 : 32'h00000000) : 32'hFFFFFFFF;

  always @(posedge clk) begin
    if (!rstN) begin
      busAck     <= 1'b0;
      busyRemain <= 0;
      togBit     <= 1'b0;
    end else if (busReq && busAck) begin
      busAck <= 1'b0;
      if (logN < DEPTH) begin
        logW[logN] <= busWrite;
        logA[logN] <= busAddr;
        logD[logN] <= busWrite ? busWdata : 32'h0;
      end
      logN <= logN + 1;
      if (busWrite && busWdata == 32'h30303030) begin
        busyRemain <= 3;
      end else if (!busWrite && busyRemain > 0) begin
        busyRemain <= busyRemain - 1;
        togBit     <= ~togBit;
      end
    end else begin
      busAck <= busReq;
    end
  end

  always @(posedge clk) begin
    if (rstN && done) doneCount <= doneCount + 1;
  end

  // Expected sequence
  logic        expW [DEPTH];
  logic [23:0] expA [DEPTH];
  logic [31:0] expD [DEPTH];
  int          expN = 0;

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pushW(input logic [23:0] a, input logic [31:0] d);
    expW[expN] = 1'b1; expA[expN] = a; expD[expN] = d; expN++;
  endtask

  task automatic pushWait();
    for (int k = 0; k < 5; k++) begin
      expW[expN] = 1'b0; expA[expN] = '0; expD[expN] = '0; expN++;
    end
  endtask

  function automatic logic [31:0] laneBits(input logic [3:0] m, input logic [7:0] b);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = m[i] ? b : 8'h00;
    return r;
  endfunction

  task automatic pushSetup(input logic t, input logic [3:0] m);
    logic [23:0] u;
    u = t ? 24'hAAAAAA : 24'h555555;
    pushW(u, laneBits(m, 8'hAA));
    pushW(~u, laneBits(m, 8'h55));
    pushW(u, 32'h80808080);
    pushW(u, laneBits(m, 8'hAA));
    pushW(~u, laneBits(m, 8'h55));
  endtask

  int logBase;
  int doneBase;
  logic gotOk;

  task automatic runErase(input logic t, input logic [23:0] a, input logic [24:0] len,
                          input logic [3:0] m, input string req);
    int waited;
    logBase  = logN;
    doneBase = doneCount;
    @(negedge clk);
    devType = t; startAddr = a; eraseLen = len; chipSel = m; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    gotOk = ok;
    check(done == 1'b1, req, "done reached", {31'b0, done}, 32'h1);
    repeat (10) @(negedge clk);
    check(busy == 1'b0 && doneCount - doneBase == 1, req, "single done pulse, idle after",
          doneCount - doneBase, 32'h1);
  endtask

  task automatic compareSeq(input string req);
    int n;
    int bad;
    n = logN - logBase;
    check(n == expN, req, "bus cycle count", n, expN);
    bad = -1;
    for (int i = 0; i < expN && i < n; i++) begin
      if (bad < 0 && (logW[logBase+i] != expW[i] || logA[logBase+i] != expA[i] ||
                      logD[logBase+i] != expD[i])) bad = i;
    end
    if (bad >= 0)
      check(1'b0, req, $sformatf("cycle %0d addr/data", bad),
            {logA[logBase+bad][15:0], logD[logBase+bad][15:0]},
            {expA[bad][15:0], expD[bad][15:0]});
    else
      check(1'b1, req, "sequence", 0, 0);
  endtask

  task automatic testReset();
    check(busy == 1'b0 && done == 1'b0 && busReq == 1'b0, "R1", "idle after reset",
          {29'b0, busy, done, busReq}, 32'h0);
  endtask

  task automatic testFamilyA();
    // R6 R5 R4 R9: two sectors from 0x3000, all lanes
    expN = 0;
    for (int s = 0; s < 2; s++) begin
      pushSetup(1'b0, 4'hF);
      pushW(24'h003000 + 24'(s) * 24'h1000, 32'h30303030);
      pushWait();
    end
    runErase(1'b0, 24'h003000, 25'h2000, 4'hF, "R6");
    compareSeq("R6");
    check(gotOk == 1'b1, "R6", "ok flag", {31'b0, gotOk}, 32'h1);
  endtask

  task automatic testMaskA();
    // R4: lanes 0 and 2 only
    expN = 0;
    pushSetup(1'b0, 4'h5);
    pushW(24'h010000, 32'h30303030);
    pushWait();
    runErase(1'b0, 24'h010000, 25'h1000, 4'h5, "R4");
    compareSeq("R4");
  endtask

  task automatic testFamilyB();
    // R7: batched sectors, one wait, mask 0xA
    expN = 0;
    pushSetup(1'b1, 4'hA);
    pushW(24'h020000, 32'h30303030);
    pushW(24'h030000, 32'h30303030);
    pushW(24'h040000, 32'h30303030);
    pushWait();
    runErase(1'b1, 24'h020000, 25'h30000, 4'hA, "R7");
    compareSeq("R7");
    check(gotOk == 1'b1, "R7", "ok flag", {31'b0, gotOk}, 32'h1);
  endtask

  task automatic testBootSplit();
    // R8: start 0, two sectors
    expN = 0;
    pushSetup(1'b1, 4'hF);
    pushW(24'h000000, 32'h30303030);
    pushW(24'h004000, 32'h30303030);
    pushW(24'h006000, 32'h30303030);
    pushW(24'h008000, 32'h30303030);
    pushW(24'h010000, 32'h30303030);
    pushWait();
    runErase(1'b1, 24'h000000, 25'h20000, 4'hF, "R8");
    compareSeq("R8");
    // R8: boot sector only
    expN = 0;
    pushSetup(1'b1, 4'hF);
    pushW(24'h000000, 32'h30303030);
    pushW(24'h004000, 32'h30303030);
    pushW(24'h006000, 32'h30303030);
    pushW(24'h008000, 32'h30303030);
    pushWait();
    runErase(1'b1, 24'h000000, 25'h10000, 4'hF, "R8");
    compareSeq("R8");
  endtask

  task automatic testMisaligned();
    expN = 0;
    runErase(1'b0, 24'h001100, 25'h1000, 4'hF, "R2");
    compareSeq("R2");
    check(gotOk == 1'b0, "R2", "misaligned address refused", {31'b0, gotOk}, 32'h0);
    runErase(1'b1, 24'h010000, 25'h1000, 4'hF, "R2");
    compareSeq("R2");
    check(gotOk == 1'b0, "R2", "length not a 64 KiB multiple refused", {31'b0, gotOk}, 32'h0);
  endtask

  task automatic testZeroLen();
    expN = 0;
    runErase(1'b1, 24'h000000, 25'h0, 4'hF, "R3");
    compareSeq("R3");
    check(gotOk == 1'b1, "R3", "zero length succeeds", {31'b0, gotOk}, 32'h1);
  endtask

  task automatic testBusyIgnore();
    int waited;
    expN = 0;
    pushSetup(1'b0, 4'hF);
    pushW(24'h005000, 32'h30303030);
    pushWait();
    logBase  = logN;
    doneBase = doneCount;
    @(negedge clk);
    devType = 1'b0; startAddr = 24'h005000; eraseLen = 25'h1000; chipSel = 4'hF; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (4) @(negedge clk);
    devType = 1'b1; startAddr = 24'h070000; eraseLen = 25'h10000; chipSel = 4'h3; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    repeat (30) @(negedge clk);
    compareSeq("R11");
    check(doneCount - doneBase == 1, "R11", "done pulses", doneCount - doneBase, 32'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testFamilyA();
    testMaskA();
    testFamilyB();
    testBootSplit();
    testMisaligned();
    testZeroLen();
    testBusyIgnore();
    check(busReq == 1'b0 && busy == 1'b0, "R1", "idle at end", {30'b0, busReq, busy}, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule